// File: doc/BRIEF.md
# NaN Screening and Quieting Stage

This block inspects one floating-point operand per cycle, in half, single or double precision. It tells the pipeline whether the value is a quiet NaN, a signaling NaN or not a NaN at all. Alongside the flags it produces two values. The first is a quieted copy of the operand. The second is the canonical default NaN for the selected format. An arithmetic unit can then forward a NaN result without rebuilding it.

Two run-time controls adapt the block to different architectural conventions. One flips the meaning of the top fraction bit, so that a set bit marks a signaling NaN instead of a quiet one. The other removes signaling NaNs altogether, so that every NaN is treated as quiet. The classification logic is combinational. The results are captured into an output register whenever an operand is presented, and they appear one cycle later with a valid strobe.

Top module: `fp_nan_screen`

## Requirements
- R1: `fmt` selects the width of the operand, which is right-aligned in `operand`: 2'b00 = binary16 (bits 15:0), 2'b01 = binary32 (bits 31:0), 2'b10 and 2'b11 = binary64. Operand bits above the selected width are ignored, and `quiet_val` and `dflt_nan` are zero above that width.
- R2: `is_nan` is 1 exactly when the exponent field is all ones and the fraction is nonzero. Infinities and finite values (including zeros and subnormals) raise none of the three flags.
- R3: With `msb_signals` = 0 and `no_snan` = 0, a NaN whose fraction MSB is 1 is quiet. A NaN whose fraction MSB is 0 is signaling.
- R4: With `msb_signals` = 1 and `no_snan` = 0, a NaN whose fraction MSB is 1 is signaling (even if the rest of the fraction is zero). A NaN whose fraction MSB is 0 is quiet.
- R5: With `no_snan` = 1, every NaN sets `is_qnan` and `is_snan` stays 0, regardless of `msb_signals`.
- R6: With `msb_signals` = 0, the quieted value of a signaling NaN is the operand with its fraction MSB set, keeping the sign and the lower fraction. Any operand that is not a signaling NaN passes through unchanged.
- R7: With `msb_signals` = 1, the quieted value of a signaling NaN is the default NaN of the format. Other operands pass through unchanged.
- R8: The default NaN has sign 0 and an all-ones exponent. Its fraction is only the MSB set when `msb_signals` = 0, and every bit but the MSB set when `msb_signals` = 1. Examples: binary16 0x7E00 / 0x7DFF, binary32 0x7FC00000 / 0x7FBFFFFF, binary64 0x7FF8000000000000 / 0x7FF7FFFFFFFFFFFF.
- R9: Results for an operand taken with `in_valid` = 1 appear on the next cycle with `out_valid` = 1. In a cycle with `in_valid` = 0, `out_valid` falls to 0 and all data outputs keep their previous values.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| fmt | input | 2 | Format select |
| operand | input | 64 | Right-aligned operand |
| msb_signals | input | 1 | 1: a set fraction MSB marks a signaling NaN |
| no_snan | input | 1 | 1: treat every NaN as quiet |
| out_valid | output | 1 | Registered results are valid |
| is_nan | output | 1 | Operand is a NaN |
| is_qnan | output | 1 | Operand is a quiet NaN |
| is_snan | output | 1 | Operand is a signaling NaN |
| quiet_val | output | 64 | Quieted operand, right-aligned |
| dflt_nan | output | 64 | Default NaN for the format, right-aligned |

## Verification
On every cycle the assertions check the following:
- the flags are consistent with one another: never both quiet and signaling, and `is_nan` equals their OR;
- the valid strobe follows its input by one cycle;
- held data stays stable;
- the no-signaling mode never yields `is_snan`;
- a non-NaN single-precision operand passes through unchanged.

Only the bench scenarios show the rest, by comparing against a field-extracting reference model:
- the exact bit patterns of the default NaN and of the quieted values in each polarity;
- the edge case of inverted polarity with a bare fraction MSB;
- that upper bus bits are ignored in the narrow formats.

// File: rtl/fp_nan_screen.sv
module fp_nan_screen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  fmt,
  input  logic [63:0] operand,
  input  logic        msb_signals,
  input  logic        no_snan,
  output logic        out_valid,
  output logic        is_nan,
  output logic        is_qnan,
  output logic        is_snan,
  output logic [63:0] quiet_val,
  output logic [63:0] dflt_nan
);

  logic [63:0] opm, top_bit, dnan;
  logic        exp_ones, frac_top, frac_rest;

  always_comb begin
    case (fmt)
      2'b00: begin
        opm       = {48'b0, operand[15:0]};
        exp_ones  = &operand[14:10];
        frac_top  = operand[9];
        frac_rest = |operand[8:0];
        top_bit   = 64'h0000_0000_0000_0200;
        dnan      = msb_signals ? 64'h0000_0000_0000_7DFF : 64'h0000_0000_0000_7E00;
      end
      2'b01: begin
        opm       = {32'b0, operand[31:0]};
        exp_ones  = &operand[30:23];
        frac_top  = operand[22];
        frac_rest = |operand[21:0];
        top_bit   = 64'h0000_0000_0040_0000;
        dnan      = msb_signals ? 64'h0000_0000_7FBF_FFFF : 64'h0000_0000_7FC0_0000;
      end
      default: begin
        opm       = operand;
        exp_ones  = &operand[62:52];
        frac_top  = operand[51];
        frac_rest = |operand[50:0];
        top_bit   = 64'h0008_0000_0000_0000;
        dnan      = msb_signals ? 64'h7FF7_FFFF_FFFF_FFFF : 64'h7FF8_0000_0000_0000;
      end
    endcase
  end

  wire nan_c  = exp_ones & (frac_top | frac_rest);
  wire top_sn = nan_c & frac_top & ~frac_rest;
  wire snan_c = ~no_snan & nan_c & (msb_signals ? frac_top : ~frac_top);
  wire qnan_c = nan_c & ~snan_c;
  wire [63:0] qv_c = !snan_c ? opm : (msb_signals ? dnan : (opm | top_bit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      is_nan    <= 1'b0;
      is_qnan   <= 1'b0;
      is_snan   <= 1'b0;
      quiet_val <= '0;
      dflt_nan  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        is_nan    <= nan_c;
        is_qnan   <= qnan_c;
        is_snan   <= snan_c;
        quiet_val <= qv_c;
        dflt_nan  <= dnan;
      end
    end
  end

  logic unused_ok;
  assign unused_ok = top_sn;

endmodule

// File: rtl/fp_nan_screen_chk.sv
module fp_nan_screen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  fmt,
  input logic [63:0] operand,
  input logic        no_snan,
  input logic        out_valid,
  input logic        is_nan,
  input logic        is_qnan,
  input logic        is_snan,
  input logic [63:0] quiet_val,
  input logic [63:0] dflt_nan
);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_qnan && is_snan)); // R3

  AST_NAN_IS_UNION: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (is_nan == (is_qnan | is_snan))); // R2

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(quiet_val) && $stable(dflt_nan) && $stable(is_nan))); // R9

  AST_NO_SNAN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && no_snan) |=> !is_snan); // R5

  AST_PASS_NON_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'b01 && operand[30:23] != 8'hFF)
      |=> (!is_nan && quiet_val == {32'b0, $past(operand[31:0])})); // R6

endmodule

bind fp_nan_screen fp_nan_screen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .operand(operand),
  .no_snan(no_snan), .out_valid(out_valid), .is_nan(is_nan), .is_qnan(is_qnan),
  .is_snan(is_snan), .quiet_val(quiet_val), .dflt_nan(dflt_nan)
);

// File: tb/sim_fp_nan_screen.sv
module sim_fp_nan_screen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [1:0]  fmt = 0;
  logic [63:0] operand = 0;
  logic        msb_signals = 0;
  logic        no_snan = 0;
  logic        out_valid, is_nan, is_qnan, is_snan;
  logic [63:0] quiet_val, dflt_nan;

  int n_chk = 0;
  int n_fail = 0;

  logic        e_n = 0, e_q = 0, e_s = 0;
  logic [63:0] e_qv = 0, e_dv = 0;

  always #10 clk = ~clk;

  fp_nan_screen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .operand(operand),
    .msb_signals(msb_signals), .no_snan(no_snan), .out_valid(out_valid),
    .is_nan(is_nan), .is_qnan(is_qnan), .is_snan(is_snan),
    .quiet_val(quiet_val), .dflt_nan(dflt_nan)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [1:0] f, input logic [63:0] op, input logic inv,
                                input logic nos, output logic n, output logic q,
                                output logic s, output logic [63:0] qv, output logic [63:0] dv);
    int fb, eb, tot;
    logic [63:0] v, e, fr, top;
    fb  = (f == 2'b00) ? 10 : (f == 2'b01) ? 23 : 52;
    eb  = (f == 2'b00) ? 5 : (f == 2'b01) ? 8 : 11;
    tot = fb + eb + 1;
    v   = (tot == 64) ? op : (op & ((64'd1 << tot) - 64'd1));
    e   = (v >> fb) & ((64'd1 << eb) - 64'd1);
    fr  = v & ((64'd1 << fb) - 64'd1);
    top = 64'd1 << (fb - 1);
    n   = (e == ((64'd1 << eb) - 64'd1)) && (fr != 0);
    if (nos) begin
      q = n; s = 0;
    end else if (!inv) begin
      q = n && ((fr & top) != 0); s = n && ((fr & top) == 0);
    end else begin
      s = n && ((fr & top) != 0); q = n && ((fr & top) == 0);
    end
    dv = (((64'd1 << eb) - 64'd1) << fb) | (inv ? (top - 64'd1) : top);
    if (!s) qv = v;
    else if (inv) qv = dv;
    else qv = v | top;
  endfunction

  task automatic apply(input logic [1:0] f, input logic [63:0] op, input logic inv,
                       input logic nos);
    string ft, qt;
    @(negedge clk);
    in_valid = 1; fmt = f; operand = op; msb_signals = inv; no_snan = nos;
    model(f, op, inv, nos, e_n, e_q, e_s, e_qv, e_dv);
    ft = nos ? "R5" : (inv ? "R4" : "R3");
    qt = inv ? "R1 R7" : "R1 R6";
    @(negedge clk);
    in_valid = 0;
    check("R9 out_valid", {63'b0, out_valid}, 64'd1);
    check("R2 is_nan", {63'b0, is_nan}, {63'b0, e_n});
    check({ft, " is_qnan"}, {63'b0, is_qnan}, {63'b0, e_q});
    check({ft, " is_snan"}, {63'b0, is_snan}, {63'b0, e_s});
    check({qt, " quiet_val"}, quiet_val, e_qv);
    check("R8 dflt_nan", dflt_nan, e_dv);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 out_valid", {63'b0, out_valid}, 64'd0);
    check("R10 flags", {61'b0, is_nan, is_qnan, is_snan}, 64'd0);
    check("R10 quiet_val", quiet_val, 64'd0);
    check("R10 dflt_nan", dflt_nan, 64'd0);
    rst_n = 1;

    for (int p = 0; p < 4; p++) begin
      logic inv, nos;
      inv = p[0]; nos = p[1];
      // binary32: snan, qnan, bare msb, inf, finite, zero, negative snan
      apply(2'b01, 64'h0000_0000_7F80_0001, inv, nos);
      apply(2'b01, 64'h0000_0000_7FC0_1234, inv, nos);
      apply(2'b01, 64'h0000_0000_7FC0_0000, inv, nos);
      apply(2'b01, 64'h0000_0000_7F80_0000, inv, nos);
      apply(2'b01, 64'h0000_0000_3F80_0000, inv, nos);
      apply(2'b01, 64'h0000_0000_0000_0000, inv, nos);
      apply(2'b01, 64'h0000_0000_FFA0_0055, inv, nos);
      // binary16 with garbage above bit 15 (R1)
      apply(2'b00, 64'hDEAD_BEEF_CAFE_7C01, inv, nos);
      apply(2'b00, 64'hFFFF_FFFF_FFFF_FE00, inv, nos);
      apply(2'b00, 64'h1234_5678_9ABC_7C00, inv, nos);
      apply(2'b00, 64'h0000_0000_0001_0001, inv, nos);
      // binary32 with garbage above bit 31
      apply(2'b01, 64'hFFFF_FFFF_7F80_0002, inv, nos);
      // binary64 and the 2'b11 code
      apply(2'b10, 64'h7FF0_0000_0000_0001, inv, nos);
      apply(2'b10, 64'hFFF8_0000_0000_00AB, inv, nos);
      apply(2'b10, 64'h7FF0_0000_0000_0000, inv, nos);
      apply(2'b11, 64'h7FF4_0000_0000_0000, inv, nos);
      apply(2'b11, 64'h4009_21FB_5444_2D18, inv, nos);
    end

    for (int i = 0; i < 200; i++) begin
      logic [63:0] r;
      logic [1:0] f;
      r = {$urandom, $urandom};
      f = 2'($urandom);
      if (i % 2 == 0) begin
        case (f)
          2'b00:   r[14:10] = 5'h1F;
          2'b01:   r[30:23] = 8'hFF;
          default: r[62:52] = 11'h7FF;
        endcase
      end
      apply(f, r, 1'($urandom), 1'($urandom));
    end

    // R9: hold when in_valid low
    apply(2'b01, 64'h0000_0000_7F80_0009, 1'b0, 1'b0);
    @(negedge clk);
    fmt = 2'b00; operand = 64'h0; msb_signals = 1; no_snan = 1;
    @(negedge clk);
    check("R9 out_valid low", {63'b0, out_valid}, 64'd0);
    check("R9 hold quiet_val", quiet_val, 64'h0000_0000_7FC0_0009);
    check("R9 hold dflt_nan", dflt_nan, 64'h0000_0000_7FC0_0000);
    check("R9 hold is_snan", {63'b0, is_snan}, 64'd1);

    // explicit default NaN values (R8)
    apply(2'b00, 64'h0, 1'b0, 1'b0); check("R8 b16 normal", dflt_nan, 64'h7E00);
    apply(2'b00, 64'h0, 1'b1, 1'b0); check("R8 b16 inverted", dflt_nan, 64'h7DFF);
    apply(2'b01, 64'h0, 1'b1, 1'b0); check("R8 b32 inverted", dflt_nan, 64'h7FBF_FFFF);
    apply(2'b10, 64'h0, 1'b0, 1'b0); check("R8 b64 normal", dflt_nan, 64'h7FF8_0000_0000_0000);

    // R10: reset clears outputs again
    @(negedge clk);
    in_valid = 1; rst_n = 0;
    @(negedge clk);
    check("R10 reset out_valid", {63'b0, out_valid}, 64'd0);
    check("R10 reset quiet_val", quiet_val, 64'd0);
    in_valid = 0; rst_n = 1;

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule